// File: doc/BRIEF.md
# Pattern occurrence counter pair

This block watches a serial bit stream and keeps a running count of how often each of two fixed 4-bit patterns appears in it. Pattern A is 1011 and pattern B is 0010. In both, the leftmost bit is the earliest bit received. Matches may overlap. The block has one Moore detector and one 3-bit count per pattern, so the two searches never disturb each other.

A qualifying enable paces the stream. A bit is taken only on a rising clock edge where the enable is high. When the enable is low, the detectors and the counts all hold. An active-low asynchronous reset clears everything. A count changes at the same edge at which its detector enters its match state. The new value is therefore visible in the cycle after the last bit of the pattern is sampled.

Top module: `seq_occ_counter`

## Requirements
- R1: While reset is low, both counts read 0. After reset, a match needs four new enabled bits, so a partial pattern taken before reset is forgotten.
- R2: `cnt_a_o` rises by one for every occurrence of 1011 in the sequence of enabled bits. The leftmost bit is received first.
- R3: `cnt_b_o` rises by one for every occurrence of 0010 in the sequence of enabled bits. The leftmost bit is received first.
- R4: On an edge where `en_i` is low, `seq_i` is ignored and neither the detectors nor the counts change. A pattern whose bits are separated by disabled cycles is still found.
- R5: A count changes at the clock edge that samples the final bit of its pattern. For the stream 0,0,1,1,0,1,1,0,1,1,0,0,1,0,0,1,0,1,1,0,1 applied in cycles 0 to 20, `cnt_a_o` reads 1 from cycle 7, 2 from cycle 10 and 3 from cycle 19. `cnt_b_o` reads 1 from cycle 14 and 2 from cycle 17.
- R6: A count at 7 goes to 0 on the next match of its pattern.
- R7: Overlapping occurrences are each counted. For example, 1011011 counts two A matches and 0010010 counts two B matches.
- R8: Driving reset low clears both counts at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Bit qualifier; low freezes the whole block |
| seq_i | input | 1 | Serial data bit |
| cnt_a_o | output | 3 | Occurrences of 1011, modulo 8 |
| cnt_b_o | output | 3 | Occurrences of 0010, modulo 8 |

## Verification
The bench applies several kinds of stimulus, each aimed at a different fault:

- **Reference stream.** It is checked cycle by cycle against the stated count table. This shows whether a count lands in the right cycle or one edge late.
- **Overlapping runs** (1011011, 0010010). These separate a detector that restarts from idle after a match from one that falls back to the longest matched prefix.
- **Patterns split by disabled cycles, and stretches with the enable low after a match.** These show whether the enable freezes both the state and the count.
- **Eight back-to-back A matches.** These exercise the wrap to 0.
- **Reset cases.** A partial pattern is followed by reset, and reset is also asserted mid-cycle. These show that reset clears the detector and acts without a clock.
- **Long pseudo-random stream with random enable.** It is compared against a shift-register model.

// File: rtl/seq_occ_pkg.sv
package seq_occ_pkg;
  localparam int unsigned PAT_LEN   = 4;
  localparam int unsigned CNT_W     = 3;
  localparam int unsigned NUM_LANES = 2;
  localparam logic [PAT_LEN-1:0] PAT_A = 4'b1011;  // msb arrives first
  localparam logic [PAT_LEN-1:0] PAT_B = 4'b0010;
endpackage

// File: rtl/seq_match_fsm.sv
// Moore detector; state = length of longest pattern prefix ending at the newest bit.
module seq_match_fsm #(
  parameter int unsigned L = 4,
  parameter logic [L-1:0] PAT = 4'b1011
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic bit_i,
  output logic hit_o,
  output logic enter_o
);
  localparam int unsigned SW = $clog2(L + 1);
  localparam logic [SW-1:0] FULL = SW'(L);

  logic [SW-1:0] state_q, state_d;

  function automatic logic pat_bit(input int idx);
    logic [L-1:0] t;
    t = PAT >> idx;
    return t[0];
  endfunction

  // longest k such that the last k bits of (prefix[cur] , b) equal prefix[k]
  function automatic logic [SW-1:0] step_len(input logic [SW-1:0] cur, input logic b);
    int s;
    logic [SW-1:0] best;
    logic ok;
    logic wj;
    s = int'(cur);
    best = '0;
    for (int k = 1; k <= int'(L); k++) begin
      ok = (k <= s + 1);
      for (int j = 0; j < int'(L); j++) begin
        if (j < k) begin
          if (j == 0)      wj = b;
          else if (j <= s) wj = pat_bit(int'(L) - 1 - (s - j));
          else             wj = 1'b0;
          if (wj != pat_bit(int'(L) - k + j)) ok = 1'b0;
        end
      end
      if (ok) best = SW'(k);
    end
    return best;
  endfunction

  always_comb begin
    state_d = state_q;
    if (en_i) state_d = step_len(state_q, bit_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= '0;
    else         state_q <= state_d;
  end

  assign hit_o   = (state_q == FULL);
  assign enter_o = en_i && (state_d == FULL);

  AST_STATE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(state_q)); // R4

  AST_STATE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q <= FULL); // R2
endmodule

// File: rtl/occ_counter.sv
module occ_counter #(
  parameter int unsigned W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (en_i && inc_i)  cnt_q <= cnt_q + 1'b1;  // wraps naturally
  end

  assign cnt_o = cnt_q;

  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cnt_q)); // R4

  AST_CNT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && inc_i && (cnt_q == '1)) |=> (cnt_q == '0)); // R6
endmodule

// File: rtl/seq_occ_counter.sv
module seq_occ_counter
  import seq_occ_pkg::*;
#(
  parameter int unsigned        P_LEN = PAT_LEN,
  parameter int unsigned        C_W   = CNT_W,
  parameter logic [P_LEN-1:0]   P_A   = PAT_A,
  parameter logic [P_LEN-1:0]   P_B   = PAT_B
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic           seq_i,
  output logic [C_W-1:0] cnt_a_o,
  output logic [C_W-1:0] cnt_b_o
);
  localparam int unsigned LANES = NUM_LANES;
  localparam logic [LANES*P_LEN-1:0] PATS = {P_B, P_A};

  logic [C_W-1:0] cnt_w [LANES];
  logic           hit_w [LANES];
  logic           ent_w [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    seq_match_fsm #(
      .L  (P_LEN),
      .PAT(PATS[g*P_LEN +: P_LEN])
    ) u_fsm (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (en_i),
      .bit_i  (seq_i),
      .hit_o  (hit_w[g]),
      .enter_o(ent_w[g])
    );

    occ_counter #(.W(C_W)) u_cnt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (en_i),
      .inc_i (ent_w[g]),
      .cnt_o (cnt_w[g])
    );

    AST_CNT_ON_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(en_i) && hit_w[g]) |-> (cnt_w[g] == C_W'($past(cnt_w[g]) + 1'b1))); // R5

    AST_CNT_NO_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !hit_w[g] |-> (cnt_w[g] == $past(cnt_w[g]))); // R2
  end

  assign cnt_a_o = cnt_w[0];
  assign cnt_b_o = cnt_w[1];
endmodule

// File: tb/seq_occ_counter_test.sv
module seq_occ_counter_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0;
  logic       seq_i = 1'b0;
  logic [2:0] cnt_a_o, cnt_b_o;

  int n_chk = 0;
  int n_err = 0;

  logic [3:0] hist;
  int         nb;
  logic [2:0] ma, mb;
  logic [15:0] lf = 16'hACE1;

  // {seq, expected A count, expected B count} per cycle after reset
  localparam logic [6:0] REF_VEC [21] = '{
    7'b0_000_000, 7'b0_000_000, 7'b1_000_000, 7'b1_000_000, 7'b0_000_000,
    7'b1_000_000, 7'b1_000_000, 7'b0_001_000, 7'b1_001_000, 7'b1_001_000,
    7'b0_010_000, 7'b0_010_000, 7'b1_010_000, 7'b0_010_000, 7'b0_010_001,
    7'b1_010_001, 7'b0_010_001, 7'b1_010_010, 7'b1_010_010, 7'b0_011_010,
    7'b1_011_010
  };

  seq_occ_counter uut (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .seq_i  (seq_i),
    .cnt_a_o(cnt_a_o),
    .cnt_b_o(cnt_b_o)
  );

  always #2 clk = ~clk;

  task automatic chk(input logic [2:0] act, input logic [2:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    hist = 4'b0; nb = 0; ma = 3'd0; mb = 3'd0;
  endtask

  task automatic step(input logic b, input logic e, input string tag);
    @(negedge clk);
    seq_i = b;
    en_i  = e;
    @(posedge clk);
    if (e) begin
      hist = {hist[2:0], b};
      nb++;
      if (nb >= 4 && hist == 4'b1011) ma = ma + 3'd1;
      if (nb >= 4 && hist == 4'b0010) mb = mb + 3'd1;
    end
    #1;
    chk(cnt_a_o, ma, {tag, " R2 count A"});
    chk(cnt_b_o, mb, {tag, " R3 count B"});
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst_ni = 1'b0;
    en_i = 1'b0;
    #1;
    chk(cnt_a_o, 3'd0, {tag, " async clear A"});
    chk(cnt_b_o, 3'd0, {tag, " async clear B"});
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    model_clear();
  endtask

  initial begin
    #(200000 * 4);
    n_err++;
    $display("FAIL R1 watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    model_clear();
    // R1 reset state
    #1;
    chk(cnt_a_o, 3'd0, "R1 reset A");
    chk(cnt_b_o, 3'd0, "R1 reset B");
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R5 reference stream, counts checked before each edge
    for (int k = 0; k < 21; k++) begin
      @(negedge clk);
      seq_i = REF_VEC[k][6];
      en_i  = 1'b1;
      chk(cnt_a_o, REF_VEC[k][5:3], $sformatf("R5 cycle %0d A", k));
      chk(cnt_b_o, REF_VEC[k][2:0], $sformatf("R5 cycle %0d B", k));
      @(posedge clk);
    end

    // R4 pattern split by disabled cycles, then hold after a match
    do_reset("R8");
    step(1, 1, "R4"); step(0, 1, "R4");
    step(0, 0, "R4"); step(0, 0, "R4"); step(1, 0, "R4");
    step(1, 1, "R4"); step(1, 1, "R4");
    chk(cnt_a_o, 3'd1, "R4 split pattern found");
    step(0, 0, "R4"); step(1, 0, "R4"); step(0, 0, "R4");
    chk(cnt_a_o, 3'd1, "R4 frozen A");
    chk(cnt_b_o, 3'd0, "R4 frozen B");

    // R8 async clear with nonzero count, R1 partial pattern forgotten
    do_reset("R8");
    step(1, 1, "R1"); step(0, 1, "R1"); step(1, 1, "R1");
    do_reset("R8");
    step(1, 1, "R1");
    chk(cnt_a_o, 3'd0, "R1 partial pattern dropped");

    // R7 overlap
    do_reset("R8");
    step(1, 1, "R7"); step(0, 1, "R7"); step(1, 1, "R7"); step(1, 1, "R7");
    step(0, 1, "R7"); step(1, 1, "R7"); step(1, 1, "R7");
    chk(cnt_a_o, 3'd2, "R7 overlap A");
    do_reset("R8");
    step(0, 1, "R7"); step(0, 1, "R7"); step(1, 1, "R7"); step(0, 1, "R7");
    step(0, 1, "R7"); step(1, 1, "R7"); step(0, 1, "R7");
    chk(cnt_b_o, 3'd2, "R7 overlap B");

    // R6 wrap after eight A matches
    do_reset("R8");
    step(1, 1, "R6");
    for (int i = 0; i < 8; i++) begin
      step(0, 1, "R6"); step(1, 1, "R6"); step(1, 1, "R6");
      if (i == 6) chk(cnt_a_o, 3'd7, "R6 at seven");
    end
    chk(cnt_a_o, 3'd0, "R6 wrapped");

    // R2 R3 pseudo-random stream with random enable
    do_reset("R8");
    for (int i = 0; i < 400; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(lf[0], lf[3] | lf[7], "R2 R3 random");
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule